// File: doc/BRIEF.md
# Sub-word addressable general register file

This block is a file of eight 32-bit general registers with one write port and two independent read ports. A port can address a whole register, its low 16-bit half, or a single byte. For the first four registers, a byte access can also address the second byte (bits 15..8) through a high-byte select. It is the operand store of an integer datapath whose instructions mix 8-, 16- and 32-bit operands on the same registers.

A narrow write merges into the existing contents: only the addressed byte lanes change. A read returns the addressed field right-aligned and zero-extended to 32 bits. An access the file cannot honour is flagged on a per-port illegal output. The write side then suppresses the update, and the read side returns zero. Reads are combinational from the stored state, and a write in the same cycle is not forwarded to them.

The design has no sequencing of its own, so it has no state machine. It uses three parts: an access decoder per port, a lane-enabled storage array and a read extractor per port.

Top module: `subword_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears all eight registers to zero.
- R2: A word write (size code 2) replaces all 32 bits of the addressed register. A word read returns all 32 bits.
- R3: A half write (size code 1) replaces bits 15..0 with wr_data[15..0] and leaves bits 31..16 unchanged. A half read returns bits 15..0 with bits 31..16 of the result at zero.
- R4: A low-byte write (size code 0, hi select 0) to any index replaces bits 7..0 with wr_data[7..0] and leaves bits 31..8 unchanged. A low-byte read returns bits 7..0 with bits 31..8 of the result at zero.
- R5: A high-byte write (size code 0, hi select 1) to index 0 to 3 writes wr_data[7..0] into bits 15..8 and changes no other bit. A high-byte read returns bits 15..8 in result bits 7..0, with bits 31..8 of the result at zero.
- R6: A high-byte access to index 4 to 7 raises that port's illegal output. As a write it changes no register. As a read it returns zero.
- R7: Size code 3 is reserved. At any index it raises the illegal output, suppresses the write, and reads as zero.
- R8: The hi select has no effect on half and word accesses.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible after the clock edge.
- R10: The two read ports are independent. Each returns its own addressed field in the same cycle.
- R11: A write changes only the addressed register. The other seven keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index (0 to 7) |
| wr_size | input | 2 | Write size: 0 byte, 1 half, 2 word, 3 reserved |
| wr_hi | input | 1 | Write high-byte select (byte size only) |
| wr_data | input | 32 | Write data, right-aligned |
| wr_illegal | output | 1 | Write access is illegal and is suppressed |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_data | output | 32 | Read port 0 field, zero-extended |
| rd0_illegal | output | 1 | Read port 0 access is illegal |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_data | output | 32 | Read port 1 field, zero-extended |
| rd1_illegal | output | 1 | Read port 1 access is illegal |

## Verification
Every register is first loaded with a distinct word. A wrong lane enable or a stale index then shows up as a wrong byte, not as a matching zero. The bench then applies narrow writes of each width and byte position. Each is followed by word reads that separate a correct merge from an overwrite or a shifted write, and by narrow reads that separate correct zero-extension from leaked upper bits. High-byte and reserved-size accesses are aimed at both halves of the index range, to tell the aliased registers from the unaliased ones. A write and a read of the same register in the same cycle checks that the old value is returned before the edge and the new value after it.

// File: rtl/subword_rf_pkg.sv
package subword_rf_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/rf_access_decode.sv
module rf_access_decode
    import subword_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int HI_REGS  = 4,
    parameter int BYTES    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    input  logic             hi,
    output logic [BYTES-1:0] lane_mask,
    output logic             lane_shift,
    output logic             illegal
);

    acc_size_e sz;

    always_comb begin
        sz         = acc_size_e'(size);
        lane_mask  = '0;
        lane_shift = 1'b0;
        illegal    = 1'b0;
        unique case (sz)
            ACC_BYTE: begin
                if (hi) begin
                    if (32'(idx) < HI_REGS) begin
                        lane_mask[1] = 1'b1;
                        lane_shift   = 1'b1;
                    end else begin
                        illegal = 1'b1;
                    end
                end else begin
                    lane_mask[0] = 1'b1;
                end
            end
            ACC_HALF: lane_mask[1:0] = 2'b11;
            ACC_WORD: lane_mask      = '1;
            ACC_RSVD: illegal        = 1'b1;
        endcase
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import subword_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int BYTES   = DATA_W / LANE_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [IDX_W-1:0]               widx,
    input  logic [BYTES-1:0]               lane_mask,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (we && (widx == IDX_W'(r))) begin
                for (int l = 0; l < BYTES; l++) begin
                    if (lane_mask[l]) begin
                        word_q[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
                    end
                end
            end
        end

        assign regs_o[r] = word_q;
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import subword_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int BYTES   = DATA_W / LANE_W
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
    input  logic [IDX_W-1:0]                idx,
    input  logic [BYTES-1:0]                lane_mask,
    input  logic                            lane_shift,
    output logic [DATA_W-1:0]               data
);

    logic [DATA_W-1:0] picked;
    logic [DATA_W-1:0] aligned;
    logic [BYTES-1:0]  keep_lanes;
    logic [DATA_W-1:0] keep_bits;

    always_comb begin
        picked     = regs_i[idx];
        aligned    = lane_shift ? {{LANE_W{1'b0}}, picked[DATA_W-1:LANE_W]} : picked;
        keep_lanes = lane_shift ? {1'b0, lane_mask[BYTES-1:1]} : lane_mask;
        for (int l = 0; l < BYTES; l++) begin
            keep_bits[l*LANE_W +: LANE_W] = {LANE_W{keep_lanes[l]}};
        end
        data = aligned & keep_bits;
    end

endmodule

// File: rtl/subword_regfile.sv
module subword_regfile
    import subword_rf_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int HI_REGS  = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int BYTES   = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_size,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_size,
    input  logic              rd0_hi,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_illegal,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_size,
    input  logic              rd1_hi,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_illegal
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    logic [BYTES-1:0]  wr_lanes;
    logic              wr_shift;
    logic [DATA_W-1:0] wr_aligned;
    logic              wr_go;

    rf_access_decode #(.NUM_REGS(NUM_REGS), .HI_REGS(HI_REGS), .BYTES(BYTES)) u_wr_dec (
        .idx(wr_idx), .size(wr_size), .hi(wr_hi),
        .lane_mask(wr_lanes), .lane_shift(wr_shift), .illegal(wr_illegal)
    );

    assign wr_aligned = wr_shift ? {wr_data[DATA_W-LANE_W-1:0], {LANE_W{1'b0}}} : wr_data;
    assign wr_go      = wr_en & ~wr_illegal;

    rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .we(wr_go), .widx(wr_idx),
        .lane_mask(wr_lanes), .wdata(wr_aligned), .regs_o(regs_q)
    );

    logic [BYTES-1:0] rd0_lanes, rd1_lanes;
    logic             rd0_shift, rd1_shift;

    rf_access_decode #(.NUM_REGS(NUM_REGS), .HI_REGS(HI_REGS), .BYTES(BYTES)) u_rd0_dec (
        .idx(rd0_idx), .size(rd0_size), .hi(rd0_hi),
        .lane_mask(rd0_lanes), .lane_shift(rd0_shift), .illegal(rd0_illegal)
    );

    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd0 (
        .regs_i(regs_q), .idx(rd0_idx), .lane_mask(rd0_lanes),
        .lane_shift(rd0_shift), .data(rd0_data)
    );

    rf_access_decode #(.NUM_REGS(NUM_REGS), .HI_REGS(HI_REGS), .BYTES(BYTES)) u_rd1_dec (
        .idx(rd1_idx), .size(rd1_size), .hi(rd1_hi),
        .lane_mask(rd1_lanes), .lane_shift(rd1_shift), .illegal(rd1_illegal)
    );

    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd1 (
        .regs_i(regs_q), .idx(rd1_idx), .lane_mask(rd1_lanes),
        .lane_shift(rd1_shift), .data(rd1_data)
    );

endmodule

// File: rtl/subword_regfile_chk.sv
module subword_regfile_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int HI_REGS  = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [1:0]                      wr_size,
    input logic                            wr_hi,
    input logic [DATA_W-1:0]               wr_data,
    input logic                            wr_illegal,
    input logic [IDX_W-1:0]                rd0_idx,
    input logic [1:0]                      rd0_size,
    input logic [DATA_W-1:0]               rd0_data,
    input logic [IDX_W-1:0]                rd1_idx,
    input logic [1:0]                      rd1_size,
    input logic [DATA_W-1:0]               rd1_data,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (regs_q == '0));

    // R2
    word_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'd2) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

    // R3
    half_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'd1) |=>
            (regs_q[$past(wr_idx)][DATA_W-1:16] == $past(regs_q[wr_idx][DATA_W-1:16]))
            && (regs_q[$past(wr_idx)][15:0] == $past(wr_data[15:0])));

    // R4
    byte_low_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'd0 && !wr_hi) |=>
            (regs_q[$past(wr_idx)][DATA_W-1:8] == $past(regs_q[wr_idx][DATA_W-1:8]))
            && (regs_q[$past(wr_idx)][7:0] == $past(wr_data[7:0])));

    // R5
    byte_read_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == 2'd0) |-> (rd0_data[DATA_W-1:8] == '0));

    // R6
    hi_alias_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_size == 2'd0 && wr_hi && 32'(wr_idx) >= HI_REGS) |-> wr_illegal);

    // R6
    hi_alias_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'd0 && wr_hi && 32'(wr_idx) >= HI_REGS) |=> $stable(regs_q));

    // R7
    rsvd_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'd3) |=> $stable(regs_q));

    // R10
    rd0_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == 2'd2) |-> (rd0_data == regs_q[rd0_idx]));

    // R10
    rd1_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rd1_size == 2'd2) |-> (rd1_data == regs_q[rd1_idx]));

    // R3
    half_read_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (rd1_size == 2'd1) |-> (rd1_data[DATA_W-1:16] == '0));

endmodule

bind subword_regfile subword_regfile_chk #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .HI_REGS(HI_REGS)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_hi(wr_hi), .wr_data(wr_data), .wr_illegal(wr_illegal),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
    .regs_q(regs_q)
);

// File: tb/subword_regfile_bench.sv
`timescale 1ns/1ps
module subword_regfile_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_size;
    logic        wr_hi;
    logic [31:0] wr_data;
    logic        wr_illegal;
    logic [2:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_size, rd1_size;
    logic        rd0_hi, rd1_hi;
    logic [31:0] rd0_data, rd1_data;
    logic        rd0_illegal, rd1_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] model [8];

    always #2 clk = ~clk;

    subword_regfile u_subword_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
        .wr_hi(wr_hi), .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
        .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi),
        .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
    );

    function automatic logic exp_illegal(logic [2:0] idx, logic [1:0] size, logic hi);
        return (size == 2'd3) || (size == 2'd0 && hi && idx >= 3'd4);
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] idx, logic [1:0] size, logic hi);
        if (exp_illegal(idx, size, hi)) return 32'h0;
        case (size)
            2'd0:    return hi ? {24'h0, model[idx][15:8]} : {24'h0, model[idx][7:0]};
            2'd1:    return {16'h0, model[idx][15:0]};
            default: return model[idx];
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(string tag, logic [2:0] idx, logic [1:0] size, logic hi, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_size = size; wr_hi = hi; wr_data = d;
        #0.5;
        check({tag, " wr_illegal"}, {31'h0, wr_illegal}, {31'h0, exp_illegal(idx, size, hi)});
        @(posedge clk);
        if (!exp_illegal(idx, size, hi)) begin
            case (size)
                2'd0: if (hi) model[idx][15:8] = d[7:0]; else model[idx][7:0] = d[7:0];
                2'd1: model[idx][15:0] = d[15:0];
                default: model[idx] = d;
            endcase
        end
        #0.5;
        wr_en = 1'b0;
    endtask

    task automatic check_rd(string tag, int p, logic [2:0] idx, logic [1:0] size, logic hi);
        @(negedge clk);
        if (p == 0) begin rd0_idx = idx; rd0_size = size; rd0_hi = hi; end
        else        begin rd1_idx = idx; rd1_size = size; rd1_hi = hi; end
        #0.5;
        if (p == 0) begin
            check(tag, rd0_data, exp_read(idx, size, hi));
            check({tag, " illegal"}, {31'h0, rd0_illegal}, {31'h0, exp_illegal(idx, size, hi)});
        end else begin
            check(tag, rd1_data, exp_read(idx, size, hi));
            check({tag, " illegal"}, {31'h0, rd1_illegal}, {31'h0, exp_illegal(idx, size, hi)});
        end
    endtask

    task automatic check_all(string tag);
        for (int r = 0; r < 8; r++) check_rd(tag, r % 2, 3'(r), 2'd2, 1'b0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 8; r++) model[r] = 32'h0;
    endtask

    task automatic t_reset();
        apply_reset();
        check_all("R1 reset clears");
    endtask

    task automatic t_word();
        for (int r = 0; r < 8; r++) do_write("R2 word", 3'(r), 2'd2, 1'b0, 32'h1111_1111 * (r + 1) ^ 32'hA5C3_0F96);
        check_all("R2 word readback");
    endtask

    task automatic t_half();
        do_write("R3 half", 3'd2, 2'd1, 1'b0, 32'hFFFF_BEEF);
        check_rd("R3 half word view", 0, 3'd2, 2'd2, 1'b0);
        check_rd("R3 half read", 1, 3'd2, 2'd1, 1'b0);
    endtask

    task automatic t_byte_low();
        do_write("R4 byte low", 3'd6, 2'd0, 1'b0, 32'hFFFF_FF5A);
        check_rd("R4 byte low word view", 0, 3'd6, 2'd2, 1'b0);
        check_rd("R4 byte low read", 1, 3'd6, 2'd0, 1'b0);
        do_write("R4 byte low r0", 3'd0, 2'd0, 1'b0, 32'h0000_00C7);
        check_rd("R4 byte low r0 word view", 1, 3'd0, 2'd2, 1'b0);
    endtask

    task automatic t_byte_high();
        do_write("R5 byte high", 3'd1, 2'd0, 1'b1, 32'hFFFF_FF3C);
        check_rd("R5 byte high word view", 0, 3'd1, 2'd2, 1'b0);
        check_rd("R5 byte high read", 1, 3'd1, 2'd0, 1'b1);
        do_write("R5 byte high r3", 3'd3, 2'd0, 1'b1, 32'h0000_0081);
        check_rd("R5 byte high r3 read", 0, 3'd3, 2'd0, 1'b1);
        check_all("R11 isolation after byte writes");
    endtask

    task automatic t_hi_illegal();
        do_write("R6 high on r5", 3'd5, 2'd0, 1'b1, 32'h0000_00EE);
        check_rd("R6 r5 unchanged", 0, 3'd5, 2'd2, 1'b0);
        check_rd("R6 high read r7", 1, 3'd7, 2'd0, 1'b1);
        check_rd("R6 high read r4", 0, 3'd4, 2'd0, 1'b1);
    endtask

    task automatic t_rsvd();
        do_write("R7 rsvd r0", 3'd0, 2'd3, 1'b0, 32'h1234_5678);
        check_rd("R7 r0 unchanged", 1, 3'd0, 2'd2, 1'b0);
        check_rd("R7 rsvd read r2", 0, 3'd2, 2'd3, 1'b0);
        check_rd("R7 rsvd read r6", 1, 3'd6, 2'd3, 1'b1);
    endtask

    task automatic t_hi_ignored();
        do_write("R8 half hi=1 r7", 3'd7, 2'd1, 1'b1, 32'h0000_4D2B);
        check_rd("R8 half hi=1 word view", 0, 3'd7, 2'd2, 1'b0);
        check_rd("R8 half read hi=1", 1, 3'd7, 2'd1, 1'b1);
        do_write("R8 word hi=1 r4", 3'd4, 2'd2, 1'b1, 32'hCAFE_F00D);
        check_rd("R8 word read hi=1", 0, 3'd4, 2'd2, 1'b1);
    endtask

    task automatic t_no_bypass();
        logic [31:0] old_v;
        old_v = model[3];
        @(negedge clk);
        rd0_idx = 3'd3; rd0_size = 2'd2; rd0_hi = 1'b0;
        wr_en = 1'b1; wr_idx = 3'd3; wr_size = 2'd2; wr_hi = 1'b0; wr_data = 32'h7E57_0B0E;
        #0.5;
        check("R9 same-cycle read returns old", rd0_data, old_v);
        @(posedge clk);
        model[3] = 32'h7E57_0B0E;
        #0.5;
        wr_en = 1'b0;
        @(negedge clk);
        check("R9 new value after edge", rd0_data, model[3]);
    endtask

    task automatic t_dual_port();
        @(negedge clk);
        rd0_idx = 3'd1; rd0_size = 2'd0; rd0_hi = 1'b1;
        rd1_idx = 3'd6; rd1_size = 2'd1; rd1_hi = 1'b0;
        #0.5;
        check("R10 port0 concurrent", rd0_data, exp_read(3'd1, 2'd0, 1'b1));
        check("R10 port1 concurrent", rd1_data, exp_read(3'd6, 2'd1, 1'b0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_hi = 1'b0; wr_data = '0;
        rd0_idx = '0; rd0_size = 2'd2; rd0_hi = 1'b0;
        rd1_idx = '0; rd1_size = 2'd2; rd1_hi = 1'b0;
        t_reset();
        t_word();
        t_half();
        t_byte_low();
        t_byte_high();
        t_hi_illegal();
        t_rsvd();
        t_hi_ignored();
        t_no_bypass();
        t_dual_port();
        check_all("R11 final isolation");
        t_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule